// File: doc/BRIEF.md
# Oscillator Frequency Window Detector

This block decides whether a recovered-clock oscillator runs within a few hundred ppm of its target. The target comes from a cheap, low-accuracy reference clock. The block runs in the oscillator clock domain. It brings the reference in through a synchronizer and counts oscillator cycles across a window of 2^WIN_LOG2 reference periods. It then compares the count against a lower and an upper limit. Both limits are worked out at elaboration for the chosen reference divisor. The reference can be divided by 64 (a 38.88 MHz reference) or by 128 (a 19.44 MHz reference), so either reference maps onto the same oscillator frequency.

A count inside the limits raises the frequency-good flag and enables the phase detector. A count outside the limits drops both and issues a coarse digital steer request: up when the oscillator is slow, down when it is fast. The verdict holds until the next window completes. The frequency-good flag reports only the frequency-window state and the presence of the reference, never lock to data.

A missing reference, or an invalid divisor code, clears every verdict output. A second divider makes a line-rate clock enable from the oscillator: every 16 cycles for the 155.52 Mbit/s rate and every 4 cycles for the 622.08 Mbit/s rate.

Top module: `freq_window_det`

## Requirements
- R1: `line_ce` pulses once every 16 `clk` cycles while `rate_fast`=0 and once every 4 cycles while `rate_fast`=1, and is never high on two consecutive cycles.
- R2: `ref_sel`=2'b10 selects reference divisor 64 and `ref_sel`=2'b11 selects divisor 128. The nominal window count is divisor × 2^WIN_LOG2 oscillator cycles.
- R3: A window count C with nominal−T ≤ C ≤ nominal+T, where T = floor(nominal×PPM_TOL/10^6), sets `freq_ok`=1 and `pd_enable`=1 with both steer outputs low.
- R4: A window count below nominal−T sets `steer_up`=1 and clears `freq_ok`, `pd_enable` and `steer_down`.
- R5: A window count above nominal+T sets `steer_down`=1 and clears `freq_ok`, `pd_enable` and `steer_up`.
- R6: If no rising reference edge arrives for MISS_CYCLES `clk` cycles, `freq_ok`, `pd_enable`, `steer_up` and `steer_down` go low within two cycles. They stay low until a full window has been measured after the reference returns.
- R7: `ref_sel` codes 2'b00 and 2'b01 are invalid. While either is applied, all four verdict outputs are low.
- R8: Any change of `ref_sel` discards the window in progress. The next verdict comes from a whole window measured with the new divisor.
- R9: While `rst` is high, all outputs are driven low on the next clock edge.
- R10: `steer_up` and `steer_down` are never high together, and `freq_ok` high implies `pd_enable` high.
- R11: Outside reset, reference loss and invalid codes, the verdict outputs change only in the cycle after a window completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-derived clock that the block runs on |
| rst | input | 1 | Synchronous active-high reset |
| ref_clk_in | input | 1 | Reference clock, asynchronous to `clk` |
| rate_fast | input | 1 | Line-rate select: 1 divides by 4, 0 divides by 16 |
| ref_sel | input | 2 | Reference divisor code (2'b10 = 64, 2'b11 = 128, others invalid) |
| freq_ok | output | 1 | Reference present and oscillator inside the window |
| pd_enable | output | 1 | Phase detector enable |
| steer_up | output | 1 | Request to raise the oscillator frequency |
| steer_down | output | 1 | Request to lower the oscillator frequency |
| line_ce | output | 1 | Line-rate clock enable |

## Verification
The bench builds the block with WIN_LOG2=5 and MISS_CYCLES=400 and leaves the other defaults. This makes the nominal counts 2048 and 4096 with tolerances of 2 and 4 counts. A single window therefore lasts only a few thousand cycles, so each offset needs only a few thousand cycles to settle.

The reference period is scaled to picosecond resolution. Offsets of ±900 and ±1400 ppm on the 128 divisor therefore land just inside and just outside the limits, even with one count of synchronizer jitter. The short loss timeout lets reference dropout and recovery, invalid codes and divisor switches all fit into one run.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

  // Tolerance in counts for a nominal count and a ppm half-width (floor).
  function automatic int unsigned ppm_span(int unsigned nom, int unsigned ppm);
    longint unsigned prod;
    prod = longint'(nom) * longint'(ppm);
    return 32'(prod / 64'd1000000);
  endfunction

  typedef enum logic [1:0] {
    VERDICT_IDLE = 2'b00,
    VERDICT_UP   = 2'b01,
    VERDICT_DOWN = 2'b10,
    VERDICT_GOOD = 2'b11
  } verdict_e;

endpackage

// File: rtl/fwd_ref_sync.sv
module fwd_ref_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise_pulse
);
  // STAGES flops for metastability, one more for edge detection
  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-1:0], async_in};
  end

  assign rise_pulse = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/fwd_ref_watch.sv
module fwd_ref_watch #(
  parameter int LIMIT = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic edge_i,
  output logic lost_o
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] quiet;

  always_ff @(posedge clk) begin
    if (rst) begin
      quiet  <= '0;
      lost_o <= 1'b1;
    end else if (edge_i) begin
      quiet  <= '0;
      lost_o <= 1'b0;
    end else if (quiet == LAST) begin
      lost_o <= 1'b1;
    end else begin
      quiet <= quiet + 1'b1;
    end
  end
endmodule

// File: rtl/fwd_win_meas.sv
module fwd_win_meas #(
  parameter int WIN_LOG2 = 6,
  parameter int CNT_W    = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             abort_i,
  input  logic             edge_i,
  output logic             done_o,
  output logic [CNT_W-1:0] count_o
);
  logic                running;
  logic [WIN_LOG2-1:0] edges;
  logic [CNT_W-1:0]    span;
  logic [CNT_W-1:0]    span_inc;

  assign span_inc = (span == '1) ? span : span + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      edges   <= '0;
      span    <= '0;
      done_o  <= 1'b0;
      count_o <= '0;
    end else if (abort_i) begin
      running <= 1'b0;
      edges   <= '0;
      span    <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (edge_i) begin
        if (running && edges == '1) begin
          // closing edge of one window opens the next
          done_o  <= 1'b1;
          count_o <= span;
          edges   <= '0;
          span    <= CNT_W'(1);
        end else if (running) begin
          edges <= edges + 1'b1;
          span  <= span_inc;
        end else begin
          running <= 1'b1;
          edges   <= '0;
          span    <= CNT_W'(1);
        end
      end else if (running) begin
        span <= span_inc;
      end
    end
  end
endmodule

// File: rtl/fwd_line_div.sv
module fwd_line_div #(
  parameter int RATIO_SLOW = 16,
  parameter int RATIO_FAST = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic fast_i,
  output logic ce_o
);
  localparam int MAXR = (RATIO_SLOW > RATIO_FAST) ? RATIO_SLOW : RATIO_FAST;
  localparam int CW   = $clog2(MAXR);
  localparam logic [CW-1:0] END_SLOW = CW'(RATIO_SLOW - 1);
  localparam logic [CW-1:0] END_FAST = CW'(RATIO_FAST - 1);

  logic [CW-1:0] phase;
  logic [CW-1:0] last;

  assign last = fast_i ? END_FAST : END_SLOW;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= '0;
      ce_o  <= 1'b0;
    end else if (phase >= last) begin
      phase <= '0;
      ce_o  <= 1'b1;
    end else begin
      phase <= phase + 1'b1;
      ce_o  <= 1'b0;
    end
  end
endmodule

// File: rtl/freq_window_det.sv
module freq_window_det #(
  parameter int WIN_LOG2    = 6,
  parameter int PPM_TOL     = 1000,
  parameter int DIV_A       = 64,
  parameter int DIV_B       = 128,
  parameter int RATE_SLOW   = 16,
  parameter int RATE_FAST   = 4,
  parameter int MISS_CYCLES = 1024,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ref_clk_in,
  input  logic       rate_fast,
  input  logic [1:0] ref_sel,
  output logic       freq_ok,
  output logic       pd_enable,
  output logic       steer_up,
  output logic       steer_down,
  output logic       line_ce
);
  import fwd_pkg::*;

  localparam int unsigned NOM_A = DIV_A * (2 ** WIN_LOG2);
  localparam int unsigned NOM_B = DIV_B * (2 ** WIN_LOG2);
  localparam int unsigned TOL_A = ppm_span(NOM_A, PPM_TOL);
  localparam int unsigned TOL_B = ppm_span(NOM_B, PPM_TOL);
  localparam int unsigned NOM_MAX = (NOM_A > NOM_B) ? NOM_A : NOM_B;
  localparam int CNT_W = $clog2(NOM_MAX * 2 + 1) + 1;
  localparam logic [CNT_W-1:0] LO_A = CNT_W'(NOM_A - TOL_A);
  localparam logic [CNT_W-1:0] HI_A = CNT_W'(NOM_A + TOL_A);
  localparam logic [CNT_W-1:0] LO_B = CNT_W'(NOM_B - TOL_B);
  localparam logic [CNT_W-1:0] HI_B = CNT_W'(NOM_B + TOL_B);

  logic             ref_rise;
  logic             ref_lost;
  logic             meas_done;
  logic [CNT_W-1:0] meas_count;
  logic [1:0]       sel_q;
  logic             sel_valid;
  logic             sel_moved;
  logic             meas_abort;
  logic [CNT_W-1:0] lim_lo;
  logic [CNT_W-1:0] lim_hi;
  verdict_e         verdict_next;

  assign sel_valid  = ref_sel[1];
  assign sel_moved  = (ref_sel != sel_q);
  assign meas_abort = ref_lost | ~sel_valid | sel_moved;

  fwd_ref_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst       (rst),
    .async_in  (ref_clk_in),
    .rise_pulse(ref_rise)
  );

  fwd_ref_watch #(.LIMIT(MISS_CYCLES)) u_watch (
    .clk   (clk),
    .rst   (rst),
    .edge_i(ref_rise),
    .lost_o(ref_lost)
  );

  fwd_win_meas #(.WIN_LOG2(WIN_LOG2), .CNT_W(CNT_W)) u_meas (
    .clk    (clk),
    .rst    (rst),
    .abort_i(meas_abort),
    .edge_i (ref_rise),
    .done_o (meas_done),
    .count_o(meas_count)
  );

  fwd_line_div #(.RATIO_SLOW(RATE_SLOW), .RATIO_FAST(RATE_FAST)) u_line (
    .clk   (clk),
    .rst   (rst),
    .fast_i(rate_fast),
    .ce_o  (line_ce)
  );

  always_ff @(posedge clk) begin
    if (rst) sel_q <= 2'b00;
    else     sel_q <= ref_sel;
  end

  // a finished window was measured entirely under sel_q
  assign lim_lo = sel_q[0] ? LO_B : LO_A;
  assign lim_hi = sel_q[0] ? HI_B : HI_A;

  always_comb begin
    if (meas_count < lim_lo)      verdict_next = VERDICT_UP;
    else if (meas_count > lim_hi) verdict_next = VERDICT_DOWN;
    else                          verdict_next = VERDICT_GOOD;
  end

  always_ff @(posedge clk) begin
    if (rst || ref_lost || !sel_valid) begin
      freq_ok    <= 1'b0;
      pd_enable  <= 1'b0;
      steer_up   <= 1'b0;
      steer_down <= 1'b0;
    end else if (meas_done) begin
      freq_ok    <= (verdict_next == VERDICT_GOOD);
      pd_enable  <= (verdict_next == VERDICT_GOOD);
      steer_up   <= (verdict_next == VERDICT_UP);
      steer_down <= (verdict_next == VERDICT_DOWN);
    end
  end
endmodule

// File: rtl/freq_window_det_chk.sv
module freq_window_det_chk (
  input logic       clk,
  input logic       rst,
  input logic [1:0] ref_sel,
  input logic       freq_ok,
  input logic       pd_enable,
  input logic       steer_up,
  input logic       steer_down,
  input logic       line_ce,
  input logic       ref_lost,
  input logic       meas_done
);
  AST_STEER_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(steer_up && steer_down)); // R10

  AST_OK_ENABLES_PD: assert property (@(posedge clk) disable iff (rst)
    freq_ok |-> pd_enable); // R10

  AST_LOSS_CLEARS: assert property (@(posedge clk) disable iff (rst)
    ref_lost |=> (!freq_ok && !pd_enable && !steer_up && !steer_down)); // R6

  AST_BAD_CODE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    !ref_sel[1] |=> (!freq_ok && !pd_enable && !steer_up && !steer_down)); // R7

  AST_VERDICT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!meas_done && !ref_lost && ref_sel[1]) |=>
      ($stable(freq_ok) && $stable(steer_up) && $stable(steer_down))); // R11

  AST_CE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    line_ce |=> !line_ce); // R1

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (!freq_ok && !pd_enable && !steer_up && !steer_down && !line_ce)); // R9
endmodule

bind freq_window_det freq_window_det_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .ref_sel   (ref_sel),
  .freq_ok   (freq_ok),
  .pd_enable (pd_enable),
  .steer_up  (steer_up),
  .steer_down(steer_down),
  .line_ce   (line_ce),
  .ref_lost  (ref_lost),
  .meas_done (meas_done)
);

// File: tb/freq_window_det_test.sv
`timescale 1ns/1ps
module freq_window_det_test;
  localparam int WLOG = 5;
  localparam int MISS = 400;
  localparam int WIN  = 2 ** WLOG;

  typedef struct packed {
    logic [1:0]         sel;
    logic signed [15:0] ppm;
    logic [3:0]         exp;   // {freq_ok, pd_enable, steer_up, steer_down}
  } vec_t;

  localparam vec_t VECS [9] = '{
    '{2'b10, 16'sd0,     4'b1100},  // R2 R3 divisor 64 nominal
    '{2'b10, 16'sd3000,  4'b0001},  // R5 fast oscillator
    '{2'b10, -16'sd3000, 4'b0010},  // R4 slow oscillator
    '{2'b10, 16'sd500,   4'b1100},  // R3
    '{2'b11, 16'sd0,     4'b1100},  // R2 divisor 128
    '{2'b11, 16'sd1400,  4'b0001},  // R5 just above high limit
    '{2'b11, 16'sd900,   4'b1100},  // R3 just inside high limit
    '{2'b11, -16'sd1400, 4'b0010},  // R4 just below low limit
    '{2'b11, -16'sd900,  4'b1100}   // R3 just inside low limit
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ref_clk_in = 1'b0;
  logic       rate_fast = 1'b0;
  logic [1:0] ref_sel = 2'b10;
  logic       freq_ok, pd_enable, steer_up, steer_down, line_ce;

  int  checks = 0;
  int  errors = 0;
  int  cur_div = 64;
  real ref_half = 640.0;
  bit  ref_on = 1'b1;

  freq_window_det #(.WIN_LOG2(WLOG), .MISS_CYCLES(MISS)) uut (
    .clk(clk), .rst(rst), .ref_clk_in(ref_clk_in), .rate_fast(rate_fast),
    .ref_sel(ref_sel), .freq_ok(freq_ok), .pd_enable(pd_enable),
    .steer_up(steer_up), .steer_down(steer_down), .line_ce(line_ce)
  );

  always #10 clk = ~clk;

  initial begin
    #7;
    forever begin
      if (ref_on) begin
        #(ref_half) ref_clk_in = ~ref_clk_in;
      end else begin
        ref_clk_in = 1'b0;
        #20;
      end
    end
  end

  task automatic set_ref(input int div, input int ppm);
    cur_div  = div;
    ref_half = div * 10.0 * (1.0 + ppm * 1.0e-6);
  endtask

  task automatic wait_refs(input int n);
    repeat (n * cur_div) @(posedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] outs();
    return {28'd0, freq_ok, pd_enable, steer_up, steer_down};
  endfunction

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int ce_n;
    set_ref(64, 0);
    repeat (5) @(posedge clk);
    @(negedge clk);
    check("R9 reset outputs", {outs(), 27'd0, line_ce}, 32'd0);
    rst = 1'b0;

    foreach (VECS[i]) begin
      ref_sel = VECS[i].sel;
      set_ref(VECS[i].sel[0] ? 128 : 64, int'(VECS[i].ppm));
      wait_refs(2 * WIN + 6);
      @(negedge clk);
      check($sformatf("R2/R3/R4/R5 vector %0d", i), outs(), {28'd0, VECS[i].exp});
    end

    // R1 line-rate enable
    rate_fast = 1'b0;
    repeat (20) @(negedge clk);
    ce_n = 0;
    for (int k = 0; k < 64; k++) begin @(negedge clk); ce_n += int'(line_ce); end
    check("R1 slow rate pulses", ce_n, 4);
    rate_fast = 1'b1;
    repeat (20) @(negedge clk);
    ce_n = 0;
    for (int k = 0; k < 64; k++) begin @(negedge clk); ce_n += int'(line_ce); end
    check("R1 fast rate pulses", ce_n, 16);

    // R6 missing reference clears a steer state, then recovers
    ref_sel = 2'b11;
    set_ref(128, 3000);
    wait_refs(2 * WIN + 6);
    @(negedge clk);
    check("R6 steer before loss", outs(), 32'b0001);
    ref_on = 1'b0;
    repeat (MISS + 20) @(negedge clk);
    check("R6 loss clears outputs", outs(), 32'd0);
    set_ref(128, 0);
    ref_on = 1'b1;
    repeat (200) @(negedge clk);
    check("R6 no verdict before full window", outs(), 32'd0);
    wait_refs(2 * WIN + 6);
    @(negedge clk);
    check("R6 recovery lock", outs(), 32'b1100);
    repeat (1000) @(negedge clk);
    check("R11 verdict held", outs(), 32'b1100);

    // R7 invalid codes
    ref_sel = 2'b01;
    repeat (4) @(negedge clk);
    check("R7 code 01 clears", outs(), 32'd0);
    ref_sel = 2'b00;
    repeat (4) @(negedge clk);
    check("R7 code 00 clears", outs(), 32'd0);
    ref_sel = 2'b11;
    wait_refs(2 * WIN + 6);
    @(negedge clk);
    check("R7 valid code relocks", outs(), 32'b1100);

    // R8 divisor switch with reference still at divisor-128 rate
    ref_sel = 2'b10;
    repeat (20) @(negedge clk);
    check("R8 old verdict kept after switch", outs(), 32'b1100);
    wait_refs(WIN + 4);
    @(negedge clk);
    check("R8 new divisor verdict", outs(), 32'b0001);

    finish_run();
  end
endmodule